// File: doc/BRIEF.md
# NAND Bus Access Phase Sequencer

This block turns one request into one timed access on an asynchronous NAND flash bus. Each access runs through a setup phase, a strobe (wait) phase and a hold phase. Every phase length is a count of system clock cycles taken from one of two timing words. Data transfers use the common-memory word. Command and address bytes use the attribute word. A read that directly follows a command or address access first inserts a programmable turnaround delay before its read strobe. The device's wait input can stretch the strobe phase for as long as it is held low.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle and both enables are set. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A producer that sees `req_ready` low keeps its request and holds `req_valid` until a later edge. Read data comes back as a single-cycle `rd_valid` pulse with no back-pressure. Bus width, data, kind and direction are sampled when the request is taken.

Top module: `nand_phase_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, `bank_en` is 1 and `wait_en` is 1. While it is low, `req_valid` starts no access: `busy` stays 0 and `ce_n` stays 1.
- R2: `busy` rises on the cycle after a request is taken and stays high until the last hold cycle. `req_ready` is low on every cycle where `busy` is high.
- R3: An access holds `ce_n` low throughout. It runs setup, then strobe, then hold, each lasting the programmed number of cycles, and a programmed 0 counts as 1. Each timing word packs setup in bits 7:0, strobe in bits 15:8, hold in bits 23:16 and the high-impedance count in bits 31:24.
- R4: `req_kind` 0 (data) and 3 (reserved, treated as data) take their timing from `mem_timing`. Kind 1 (command) and kind 2 (address) take their timing from `att_timing`.
- R5: A command access drives `cle` high and an address access drives `ale` high, each for its whole access. Both kinds always write, whatever `req_write` says. A data access drives neither signal.
- R6: A write pulls `we_n` low and a read pulls `re_n` low, only during the strobe phase. The two strobes are never low together.
- R7: While `wait_en` is 1 and `wait_n` is low during the strobe phase, the strobe stays low and the phase count does not advance. Each such cycle lengthens the phase by one.
- R8: On a write, `dq_oe` rises once `hiz` setup cycles have elapsed and stays high through the end of hold. If `hiz` is not smaller than the setup length, it rises with the strobe. A read never drives `dq_oe`.
- R9: A data read whose previous access was a command adds `cle_re_dly`+1 cycles, with strobes high, before its setup phase. After an address access it adds `ale_re_dly`+1 cycles instead. After any other access it adds nothing.
- R10: When `bus_width` is 1, a data write drives all 16 bits of `dq_out` and a read returns all 16 bits. Codes 0, 2 and 3 select 8-bit mode, where the upper byte is 0. Command and address bytes always drive only the low byte.
- R11: A read samples `dq_in` at the end of the final strobe cycle. `rd_valid` is high for the first hold cycle only, with the sampled value on `rd_data`.
- R12: During reset, `ce_n`, `we_n` and `re_n` are 1, and `cle`, `ale`, `dq_oe`, `busy` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_timing | input | 32 | Common-memory timing word (data accesses) |
| att_timing | input | 32 | Attribute timing word (command/address accesses) |
| cle_re_dly | input | 4 | Turnaround cycles minus one after a command access |
| ale_re_dly | input | 4 | Turnaround cycles minus one after an address access |
| bus_width | input | 2 | 1 = 16-bit, other codes = 8-bit |
| wait_en | input | 1 | Wait-input enable (needed to accept requests) |
| bank_en | input | 1 | Bank enable (needed to accept requests) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 treated as data |
| req_write | input | 1 | 1 = write (data kind only) |
| req_wdata | input | 16 | Write data or command/address byte |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 16 | Read data |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 16 | Data bus input value |
| wait_n | input | 1 | Device wait input, low stretches the strobe |

## Verification
The hardest case to reach is the read turnaround, because it depends on the kind of the access that came before. The stimulus therefore issues a command, or an address, and then immediately a read, and measures how many cycles pass before `re_n` falls. Strobe stretching needs `wait_n` pulled low in the strobe's first cycle. The bench watches for the falling strobe and then holds `wait_n` low for a known number of edges.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam int FW = 8;   // width of each phase-length field
  localparam int DW = 4;   // width of each read turnaround field

  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_CMD  = 2'd1,
    K_ADDR = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DLY   = 3'd1,
    PH_SETUP = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;

  // one timing word, most significant field first
  typedef struct packed {
    logic [FW-1:0] hiz;
    logic [FW-1:0] hold;
    logic [FW-1:0] wt;
    logic [FW-1:0] setup;
  } tset_t;

  // resolved plan for one access
  typedef struct packed {
    logic [FW-1:0] setup;
    logic [FW-1:0] wt;
    logic [FW-1:0] hold;
    logic [FW-1:0] hiz;
    logic [FW-1:0] dly;
    logic          need_dly;
  } plan_t;

  function automatic logic [FW-1:0] at_least_one(input logic [FW-1:0] v);
    return (v == '0) ? FW'(1) : v;
  endfunction
endpackage

// File: rtl/nps_timing_sel.sv
module nps_timing_sel
  import nps_pkg::*;
(
  input  tset_t           mem_set,
  input  tset_t           att_set,
  input  kind_e           kind,
  input  logic            is_read,
  input  kind_e           last_kind,
  input  logic [DW-1:0]   cle_dly,
  input  logic [DW-1:0]   ale_dly,
  output plan_t           plan
);
  tset_t sel;

  always_comb begin
    sel = (kind == K_CMD || kind == K_ADDR) ? att_set : mem_set;
    plan.setup    = at_least_one(sel.setup);
    plan.wt       = at_least_one(sel.wt);
    plan.hold     = at_least_one(sel.hold);
    plan.hiz      = sel.hiz;
    plan.need_dly = is_read && (last_kind == K_CMD || last_kind == K_ADDR);
    plan.dly      = FW'((last_kind == K_CMD) ? cle_dly : ale_dly) + FW'(1);
  end
endmodule

// File: rtl/nps_phase_fsm.sv
module nps_phase_fsm
  import nps_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  plan_t           plan,
  input  kind_e           kind_in,
  input  logic            wr_in,
  input  logic [DQ_W-1:0] wdata_in,
  input  logic            stall,
  output phase_e          phase,
  output logic [FW-1:0]   cnt,
  output logic [FW-1:0]   setup_q,
  output logic [FW-1:0]   hiz_q,
  output kind_e           kind_q,
  output logic            wr_q,
  output logic [DQ_W-1:0] wdata_q,
  output kind_e           last_kind,
  output logic            wait_done
);
  logic [FW-1:0] wt_q, hold_q;
  logic          cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign wait_done = (phase == PH_WAIT) && cnt_zero && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      setup_q   <= '0;
      wt_q      <= '0;
      hold_q    <= '0;
      hiz_q     <= '0;
      kind_q    <= K_DATA;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      last_kind <= K_DATA;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          setup_q <= plan.setup;
          wt_q    <= plan.wt;
          hold_q  <= plan.hold;
          hiz_q   <= plan.hiz;
          kind_q  <= kind_in;
          wr_q    <= wr_in;
          wdata_q <= wdata_in;
          if (plan.need_dly) begin
            phase <= PH_DLY;
            cnt   <= plan.dly - FW'(1);
          end else begin
            phase <= PH_SETUP;
            cnt   <= plan.setup - FW'(1);
          end
        end
        PH_DLY: if (cnt_zero) begin
          phase <= PH_SETUP;
          cnt   <= setup_q - FW'(1);
        end else cnt <= cnt - FW'(1);
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_WAIT;
          cnt   <= wt_q - FW'(1);
        end else cnt <= cnt - FW'(1);
        PH_WAIT: if (!stall) begin
          if (cnt_zero) begin
            phase <= PH_HOLD;
            cnt   <= hold_q - FW'(1);
          end else cnt <= cnt - FW'(1);
        end
        PH_HOLD: if (cnt_zero) begin
          phase     <= PH_IDLE;
          last_kind <= kind_q;
        end else cnt <= cnt - FW'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nps_pin_drive.sv
module nps_pin_drive
  import nps_pkg::*;
(
  input  phase_e        phase,
  input  logic [FW-1:0] cnt,
  input  logic [FW-1:0] setup_q,
  input  logic [FW-1:0] hiz_q,
  input  kind_e         kind_q,
  input  logic          wr_q,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic          dq_oe
);
  logic          active, strobe;
  logic [FW:0]   hiz_sum;

  always_comb begin
    active  = (phase != PH_IDLE);
    strobe  = (phase == PH_WAIT);
    hiz_sum = {1'b0, cnt} + {1'b0, hiz_q};
    ce_n    = !active;
    cle     = active && (kind_q == K_CMD);
    ale     = active && (kind_q == K_ADDR);
    we_n    = !(strobe && wr_q);
    re_n    = !(strobe && !wr_q);
    dq_oe   = wr_q && (strobe || (phase == PH_HOLD) ||
              ((phase == PH_SETUP) && (hiz_sum < {1'b0, setup_q})));
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nps_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     mem_timing,
  input  logic [31:0]     att_timing,
  input  logic [3:0]      cle_re_dly,
  input  logic [3:0]      ale_re_dly,
  input  logic [1:0]      bus_width,
  input  logic            wait_en,
  input  logic            bank_en,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_write,
  input  logic [DQ_W-1:0] req_wdata,
  output logic            busy,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  input  logic [DQ_W-1:0] dq_in,
  input  logic            wait_n
);
  localparam int LO_W = DQ_W / 2;
  localparam logic [DQ_W-1:0] LO_MASK = {{(DQ_W-LO_W){1'b0}}, {LO_W{1'b1}}};

  kind_e           kind_in, kind_q, last_kind;
  phase_e          phase;
  plan_t           plan;
  logic            is_data, wr_in, start, stall, wait_done, wide, wide_q, wr_q;
  logic [FW-1:0]   cnt, setup_q, hiz_q;
  logic [DQ_W-1:0] wdata_m;

  assign kind_in   = kind_e'(req_kind);
  assign is_data   = (kind_in == K_DATA) || (kind_in == K_RSVD);
  assign wr_in     = req_write || !is_data;
  assign wide      = (bus_width == 2'd1);
  assign wdata_m   = (wide && is_data) ? req_wdata : (req_wdata & LO_MASK);
  assign req_ready = (phase == PH_IDLE) && bank_en && wait_en;
  assign start     = req_valid && req_ready;
  assign stall     = wait_en && !wait_n;
  assign busy      = (phase != PH_IDLE);

  nps_timing_sel u_sel (
    .mem_set   (tset_t'(mem_timing)),
    .att_set   (tset_t'(att_timing)),
    .kind      (kind_in),
    .is_read   (!wr_in),
    .last_kind (last_kind),
    .cle_dly   (cle_re_dly),
    .ale_dly   (ale_re_dly),
    .plan      (plan)
  );

  nps_phase_fsm #(.DQ_W(DQ_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .plan      (plan),
    .kind_in   (kind_in),
    .wr_in     (wr_in),
    .wdata_in  (wdata_m),
    .stall     (stall),
    .phase     (phase),
    .cnt       (cnt),
    .setup_q   (setup_q),
    .hiz_q     (hiz_q),
    .kind_q    (kind_q),
    .wr_q      (wr_q),
    .wdata_q   (dq_out),
    .last_kind (last_kind),
    .wait_done (wait_done)
  );

  nps_pin_drive u_pins (
    .phase   (phase),
    .cnt     (cnt),
    .setup_q (setup_q),
    .hiz_q   (hiz_q),
    .kind_q  (kind_q),
    .wr_q    (wr_q),
    .ce_n    (ce_n),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .re_n    (re_n),
    .dq_oe   (dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (start) wide_q <= wide;
      rd_valid <= wait_done && !wr_q;
      if (wait_done && !wr_q)
        rd_data <= wide_q ? dq_in : (dq_in & LO_MASK);
    end
  end
endmodule

// File: rtl/nps_checker.sv
module nps_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic wait_n,
  input logic wait_en,
  input logic bank_en,
  input logic rd_valid
);
  // R1
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bank_en && wait_en && !busy));
  // R2
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R3
  ce_during_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ce_n);
  // R5
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && !wait_n && (!we_n || !re_n)) |=> (!we_n || !re_n));
  // R8
  oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && re_n));
  // R11
  rdv_after_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!re_n) && re_n));
endmodule

bind nand_phase_seq nps_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .ce_n      (ce_n),
  .cle       (cle),
  .ale       (ale),
  .we_n      (we_n),
  .re_n      (re_n),
  .dq_oe     (dq_oe),
  .wait_n    (wait_n),
  .wait_en   (wait_en),
  .bank_en   (bank_en),
  .rd_valid  (rd_valid)
);

// File: tb/nand_phase_seq_tb.sv
`timescale 1ns/1ps
module nand_phase_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_timing = 32'h0;
  logic [31:0] att_timing = 32'h0;
  logic [3:0]  cle_re_dly = 4'd0;
  logic [3:0]  ale_re_dly = 4'd0;
  logic [1:0]  bus_width = 2'd0;
  logic        wait_en = 1'b0, bank_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_wdata = 16'h0, dq_in = 16'h0;
  logic        wait_n = 1'b1;
  logic        req_ready, busy, rd_valid, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [15:0] rd_data, dq_out;

  int n_chk = 0, n_fail = 0;
  int pre, strb, post, oe_first, oe_cnt, cle_cnt, ale_cnt, we_cnt, re_cnt;
  int rdy_busy, rdv_cnt, rdv_idx, total;
  logic [15:0] dq_seen, rdq;

  always #2.5 clk = ~clk;

  nand_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_timing(mem_timing), .att_timing(att_timing),
    .cle_re_dly(cle_re_dly), .ale_re_dly(ale_re_dly), .bus_width(bus_width),
    .wait_en(wait_en), .bank_en(bank_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_write(req_write), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .wait_n(wait_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] kind, input logic wr, input logic [15:0] data,
                        input int stall);
    int i, left;
    bit started;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    pre = 0; strb = 0; post = 0; oe_first = -1; oe_cnt = 0; cle_cnt = 0; ale_cnt = 0;
    we_cnt = 0; re_cnt = 0; rdy_busy = 0; rdv_cnt = 0; rdv_idx = -1;
    dq_seen = 16'h0; rdq = 16'h0; i = 0; left = 0; started = 0;
    while (busy && i < 3000) begin
      if (!we_n || !re_n) begin strb++; dq_seen = dq_out; end
      else if (strb == 0) pre++;
      else post++;
      if (dq_oe) begin oe_cnt++; if (oe_first < 0) oe_first = i; end
      if (cle) cle_cnt++;
      if (ale) ale_cnt++;
      if (!we_n) we_cnt++;
      if (!re_n) re_cnt++;
      if (req_ready) rdy_busy++;
      if (rd_valid) begin rdv_cnt++; rdv_idx = i; rdq = rd_data; end
      if (strb == 1 && (!we_n || !re_n) && stall > 0 && !started) begin
        wait_n = 1'b0; started = 1; left = stall;
      end else if (started && left > 0) begin
        left--;
        if (left == 0) wait_n = 1'b1;
      end
      i++;
      @(negedge clk);
    end
    total = i;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12", "ce_n in reset", ce_n, 1);
    chk("R12", "we_n/re_n in reset", {we_n, re_n}, 3);
    chk("R12", "cle/ale/oe in reset", {cle, ale, dq_oe}, 0);
    chk("R12", "busy/rd_valid in reset", {busy, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready with enables clear", req_ready, 0);
    wait_en = 1'b1; bank_en = 1'b1;
    @(negedge clk);
    chk("R1", "ready with both enables", req_ready, 1);
  endtask

  task automatic t_data_write;
    mem_timing = 32'h02_03_04_05; bus_width = 2'd0;
    access(2'd0, 1'b1, 16'hA5C3, 0);
    chk("R3", "setup cycles", pre, 5);
    chk("R3", "strobe cycles", strb, 4);
    chk("R3", "hold cycles", post, 3);
    chk("R6", "we_n low count", we_cnt, 4);
    chk("R6", "re_n low on write", re_cnt, 0);
    chk("R8", "oe first cycle", oe_first, 2);
    chk("R8", "oe cycle count", oe_cnt, 10);
    chk("R5", "cle/ale on data", cle_cnt + ale_cnt, 0);
    chk("R10", "8-bit write data", dq_seen, 16'h00C3);
    chk("R2", "ready while busy", rdy_busy, 0);
    chk("R2", "busy length", total, 12);
  endtask

  task automatic t_zero_fields;
    mem_timing = 32'h0;
    access(2'd0, 1'b1, 16'h0011, 0);
    chk("R3", "zero setup as 1", pre, 1);
    chk("R3", "zero strobe as 1", strb, 1);
    chk("R3", "zero hold as 1", post, 1);
    chk("R8", "oe from setup start", oe_first, 0);
  endtask

  task automatic t_cmd_then_read;
    att_timing = 32'h01_02_03_02; bus_width = 2'd1; cle_re_dly = 4'd3;
    access(2'd1, 1'b0, 16'h1290, 0);
    chk("R4", "cmd setup from attribute word", pre, 2);
    chk("R4", "cmd strobe from attribute word", strb, 3);
    chk("R4", "cmd hold from attribute word", post, 2);
    chk("R5", "cle whole access", cle_cnt, 7);
    chk("R5", "cmd forced write", we_cnt, 3);
    chk("R10", "cmd low byte only", dq_seen, 16'h0090);
    mem_timing = 32'h00_02_02_03; dq_in = 16'hBEEF;
    access(2'd0, 1'b0, 16'h0, 0);
    chk("R9", "cle turnaround + setup", pre, 7);
    chk("R6", "re_n low count", re_cnt, 2);
    chk("R8", "no oe on read", oe_cnt, 0);
    chk("R11", "rd_valid count", rdv_cnt, 1);
    chk("R11", "rd_valid cycle", rdv_idx, 9);
    chk("R10", "16-bit read data", rdq, 16'hBEEF);
  endtask

  task automatic t_addr_then_read;
    bus_width = 2'd0; ale_re_dly = 4'd0;
    access(2'd2, 1'b1, 16'h0033, 0);
    chk("R5", "ale whole access", ale_cnt, 7);
    chk("R5", "no cle on address", cle_cnt, 0);
    access(2'd0, 1'b0, 16'h0, 0);
    chk("R9", "ale turnaround + setup", pre, 4);
    chk("R10", "8-bit read data", rdq, 16'h00EF);
    access(2'd0, 1'b0, 16'h0, 0);
    chk("R9", "no turnaround after data", pre, 3);
  endtask

  task automatic t_stretch;
    mem_timing = 32'h02_03_04_05;
    access(2'd0, 1'b1, 16'h0044, 3);
    chk("R7", "stretched strobe", strb, 7);
    chk("R7", "hold after stretch", post, 3);
  endtask

  task automatic t_gate;
    bank_en = 1'b0;
    @(negedge clk);
    chk("R1", "ready with bank off", req_ready, 0);
    req_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1", "no access while gated", {busy, ~ce_n}, 0);
    end
    req_valid = 1'b0; bank_en = 1'b1; wait_en = 1'b0;
    @(negedge clk);
    chk("R1", "ready with wait off", req_ready, 0);
    wait_en = 1'b1;
  endtask

  task automatic t_hiz_late_and_width;
    mem_timing = 32'h09_01_01_02;
    access(2'd0, 1'b1, 16'h0055, 0);
    chk("R8", "oe starts with strobe", oe_first, 2);
    chk("R8", "oe count late", oe_cnt, 2);
    mem_timing = 32'h0; bus_width = 2'd1;
    access(2'd0, 1'b1, 16'hA5C3, 0);
    chk("R10", "16-bit write data", dq_seen, 16'hA5C3);
    bus_width = 2'd2;
    access(2'd3, 1'b1, 16'hA5C3, 0);
    chk("R10", "reserved width is 8-bit", dq_seen, 16'h00C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_data_write();
    t_zero_fields();
    t_cmd_then_read();
    t_addr_then_read();
    t_stretch();
    t_gate();
    t_hiz_late_and_width();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule